// File: doc/BRIEF.md
# A/D Conversion Scan Sequencer

This block sequences an external analog-to-digital converter under control of an 8-bit control register. Software picks a conversion clock rate, a single channel or a scan over a channel group, and whether a scan repeats. Conversion then begins in one of three ways: software sets the start bit, a falling edge arrives on the external trigger pin, or a timer pulse arrives while triggering is enabled.

For each channel the sequencer sends a one-cycle start pulse and a channel number to the converter. It also supplies a conversion-clock enable that the converter counts. When the converter returns a done pulse with a 10-bit result, the result is stored in that channel's result register. The start bit doubles as the busy indication. Hardware clears it at the end of a single conversion or of a single-cycle scan. In continuous scan it stays set until software clears it. A sticky done flag marks the end of every single conversion and every scan pass.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control register reads 0x00, and conv_start and conv_clk_en are low.
- R2: The control register fields are trigger enable in bit 7, clock select in bits 6:5, start in bit 4, continuous select in bit 3 and the done flag in bit 2. Bits 1:0 read 0. Every field except the done flag reads back as written.
- R3: While start is 1, conv_clk_en pulses for one cycle every 32, 16, 8 or 4 clocks for clock select 0, 1, 2 or 3. While start is 0 it stays low.
- R4: A write that sets start produces a one-cycle conv_start pulse in the second cycle after the write edge. conv_ch is group*4 + channel index.
- R5: In single mode (scan_mode=0) exactly one conversion of channel grp_sel*4+ch_sel is made. Start clears at the done edge, and the continuous select has no effect.
- R6: In scan mode, channels grp_sel*4+0 up to grp_sel*4+ch_sel are converted in ascending order, one conv_start each. With continuous select 0, start clears after the last one.
- R7: In scan mode with continuous select 1, passes repeat from index 0 and start stays 1.
- R8: Writing start=0 stops at once. conv_clk_en is low from the next cycle, no further conv_start follows, and no done flag or result write results.
- R9: With trigger enable 0, ext_trig_n and tmr_trig are ignored. With trigger enable 1, a falling edge of ext_trig_n (after a two-flop synchronizer) or a tmr_trig pulse sets start.
- R10: A trigger that arrives while start is 1 is ignored and causes no further conversion.
- R11: At each accepted done pulse, conv_result is stored for the converting channel and is readable on rd_data when rd_ch selects it.
- R12: The done flag is set at the end of each single conversion and each scan pass. Writing 0 to bit 2 clears it, and writing 1 has no effect. A hardware set wins over a same-cycle clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Write data for control bits 7:2 |
| ctl_rdata | output | 8 | Control register read value |
| scan_mode | input | 1 | 1 selects scan, 0 selects single channel |
| grp_sel | input | 1 | Channel group select |
| ch_sel | input | 2 | Channel index (single) or last index (scan) |
| ext_trig_n | input | 1 | Asynchronous external trigger, falling edge active |
| tmr_trig | input | 1 | Synchronous timer trigger pulse |
| conv_clk_en | output | 1 | Conversion clock enable pulse |
| conv_start | output | 1 | Start pulse to the converter |
| conv_ch | output | 3 | Channel being converted |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 10 | Converter result, valid with conv_done |
| rd_ch | input | 3 | Result register select |
| rd_data | output | 10 | Selected result register |

## Verification
A write lands at clock edge E. The start bit and the read value change at E, conv_clk_en falls by the next cycle, and conv_start appears after one more edge. The bench samples these at the first and second falling edges after E. Each done pulse is driven on a falling edge and accepted at the next rising edge, where the result register, the done flag and the cleared start bit all change together. The bench therefore polls for the done flag on falling edges with a bound derived from divider × 20 ticks × channel count, and checks the start bit and results on that same falling edge. The external trigger passes three register stages before start is set, so its checks wait four cycles.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LAUNCH = 2'd1,
    SEQ_WAIT   = 2'd2
  } seq_state_e;

  localparam int unsigned CTL_TRIG_EN = 7;
  localparam int unsigned CTL_CLK_HI  = 6;
  localparam int unsigned CTL_CLK_LO  = 5;
  localparam int unsigned CTL_START   = 4;
  localparam int unsigned CTL_CONT    = 3;
  localparam int unsigned CTL_DONE    = 2;

endpackage

// File: rtl/adc_conv_clkdiv.sv
module adc_conv_clkdiv #(
  parameter int DIV_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] clk_sel,
  output logic       tick
);

  logic [DIV_LOG2-1:0] cnt_q, cnt_d, lim;

  // divide by 2^DIV_LOG2 >> clk_sel
  assign lim  = {DIV_LOG2{1'b1}} >> clk_sel;
  assign tick = run && (cnt_q >= lim);

  always_comb begin
    if (!run)            cnt_d = '0;
    else if (cnt_q >= lim) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the smallest divider is 4, so ticks never sit back to back
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/adc_trig_detect.sv
module adc_trig_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_trig_n,
  input  logic tmr_trig,
  input  logic trig_en,
  output logic trig_req
);

  logic [2:0] sync_q, sync_d;
  logic       fall;

  assign sync_d   = {sync_q[1:0], ext_trig_n};
  assign fall     = sync_q[2] & ~sync_q[1];
  assign trig_req = trig_en & (fall | tmr_trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= sync_d;
  end

  // R9: one falling edge yields a single-cycle detect
  assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
  import adc_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:2] wdata,
  input  logic       trig_req,
  input  logic       hw_clr_start,
  input  logic       hw_set_done,
  output logic       trig_en,
  output logic [1:0] clk_sel,
  output logic       start,
  output logic       cont,
  output logic [7:0] rdata
);

  logic       trig_en_q, trig_en_d;
  logic [1:0] clk_sel_q, clk_sel_d;
  logic       start_q, start_d;
  logic       cont_q, cont_d;
  logic       done_q, done_d;

  always_comb begin
    trig_en_d = trig_en_q;
    clk_sel_d = clk_sel_q;
    cont_d    = cont_q;
    start_d   = start_q;
    done_d    = done_q;
    if (we) begin
      trig_en_d = wdata[CTL_TRIG_EN];
      clk_sel_d = wdata[CTL_CLK_HI:CTL_CLK_LO];
      cont_d    = wdata[CTL_CONT];
      start_d   = wdata[CTL_START];
    end else if (hw_clr_start) begin
      start_d = 1'b0;
    end else if (trig_req && !start_q) begin
      start_d = 1'b1;
    end
    if (hw_set_done)                   done_d = 1'b1;
    else if (we && !wdata[CTL_DONE])   done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_en_q <= 1'b0;
      clk_sel_q <= 2'b00;
      start_q   <= 1'b0;
      cont_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      trig_en_q <= trig_en_d;
      clk_sel_q <= clk_sel_d;
      start_q   <= start_d;
      cont_q    <= cont_d;
      done_q    <= done_d;
    end
  end

  assign trig_en = trig_en_q;
  assign clk_sel = clk_sel_q;
  assign start   = start_q;
  assign cont    = cont_q;
  assign rdata   = {trig_en_q, clk_sel_q, start_q, cont_q, done_q, 2'b00};

  // R9: with triggering off and no write, an idle block stays idle
  assert_trig_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_en_q && !we && !start_q) |=> !start_q);

  // R12: the done flag only falls through a software write of 0
  assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(we && !wdata[CTL_DONE])) |=> done_q);

  // R5: end of a non-repeating run drops start
  assert_hw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr_start && !we) |=> !start_q);

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int GRP_W = 1,
  localparam int CH_W = IDX_W + GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scan_mode,
  input  logic             cont,
  input  logic [GRP_W-1:0] grp_sel,
  input  logic [IDX_W-1:0] ch_sel,
  input  logic             conv_done,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  output logic             wr_en,
  output logic             pass_end,
  output logic             clr_start
);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign last    = !scan_mode || (idx_q == ch_sel);
  assign conv_ch = {grp_sel, idx_q};

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    conv_start = 1'b0;
    wr_en      = 1'b0;
    pass_end   = 1'b0;
    clr_start  = 1'b0;
    if (!start) begin
      st_d = SEQ_IDLE;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          idx_d = scan_mode ? '0 : ch_sel;
          st_d  = SEQ_LAUNCH;
        end
        SEQ_LAUNCH: begin
          conv_start = 1'b1;
          st_d       = SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (conv_done) begin
            wr_en = 1'b1;
            if (last) begin
              pass_end = 1'b1;
              if (scan_mode && cont) begin
                idx_d = '0;
                st_d  = SEQ_LAUNCH;
              end else begin
                clr_start = 1'b1;
                st_d      = SEQ_IDLE;
              end
            end else begin
              idx_d = idx_q + 1'b1;
              st_d  = SEQ_LAUNCH;
            end
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  // R4: a launch lasts one cycle
  assert_launch_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R8: a cleared start bit returns the sequencer to idle next cycle
  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (st_q == SEQ_IDLE));

  // R6: a scan leaving idle begins at the lowest index
  assert_scan_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && scan_mode && $past(st_q) == SEQ_IDLE) |-> (idx_q == '0));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [RES_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data
);

  logic [NCH-1:0][RES_W-1:0] res_q, res_d;
  logic [NCH-1:0]            hit;

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign hit[c] = wr_en && (wr_ch == CH_W'(c));
  end

  always_comb begin
    res_d = res_q;
    for (int c = 0; c < NCH; c++) begin
      if (hit[c]) res_d[c] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign rd_data = res_q[rd_ch];

  // R11: a write lands in the addressed register
  assert_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (res_q[$past(wr_ch)] == $past(wr_data)));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int GRP_CH   = 4,
  parameter int RES_W    = 10,
  parameter int DIV_LOG2 = 5,
  localparam int CH_W    = $clog2(NCH),
  localparam int IDX_W   = $clog2(GRP_CH),
  localparam int GRP_W   = CH_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:2]       ctl_wdata,
  output logic [7:0]       ctl_rdata,
  input  logic             scan_mode,
  input  logic [GRP_W-1:0] grp_sel,
  input  logic [IDX_W-1:0] ch_sel,
  input  logic             ext_trig_n,
  input  logic             tmr_trig,
  output logic             conv_clk_en,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data
);

  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       trig_en, start, cont, trig_req;
  logic [1:0] clk_sel;
  logic       wr_en, pass_end, clr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  adc_ctl_reg u_ctl (
    .clk          (clk),
    .rst_n        (rst_i),
    .we           (ctl_we),
    .wdata        (ctl_wdata),
    .trig_req     (trig_req),
    .hw_clr_start (clr_start),
    .hw_set_done  (pass_end),
    .trig_en      (trig_en),
    .clk_sel      (clk_sel),
    .start        (start),
    .cont         (cont),
    .rdata        (ctl_rdata)
  );

  adc_trig_detect u_trig (
    .clk        (clk),
    .rst_n      (rst_i),
    .ext_trig_n (ext_trig_n),
    .tmr_trig   (tmr_trig),
    .trig_en    (trig_en),
    .trig_req   (trig_req)
  );

  adc_conv_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk     (clk),
    .rst_n   (rst_i),
    .run     (start),
    .clk_sel (clk_sel),
    .tick    (conv_clk_en)
  );

  adc_scan_fsm #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_i),
    .start      (start),
    .scan_mode  (scan_mode),
    .cont       (cont),
    .grp_sel    (grp_sel),
    .ch_sel     (ch_sel),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .wr_en      (wr_en),
    .pass_end   (pass_end),
    .clr_start  (clr_start)
  );

  adc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_i),
    .wr_en   (wr_en),
    .wr_ch   (conv_ch),
    .wr_data (conv_result),
    .rd_ch   (rd_ch),
    .rd_data (rd_data)
  );

  // R8: a stop write silences both converter outputs next cycle
  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (ctl_we && !ctl_wdata[CTL_START]) |=> (!conv_clk_en && !conv_start));

  // R7: a continuous scan keeps start set without a write
  assert_cont_hold_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (ctl_rdata[CTL_START] && scan_mode && ctl_rdata[CTL_CONT] && !ctl_we)
      |=> ctl_rdata[CTL_START]);

endmodule

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;

  localparam int CONV_TICKS = 20;
  localparam int NVEC = 6;
  // {scan, cont, grp, ch_sel[1:0], clk_sel[1:0], exp_count[2:0], exp_first[2:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 2'd2, 2'd3, 3'd1, 3'd2},
    {1'b0, 1'b1, 1'b1, 2'd1, 2'd2, 3'd1, 3'd1},
    {1'b1, 1'b0, 1'b0, 2'd3, 2'd3, 3'd4, 3'd0},
    {1'b1, 1'b0, 1'b1, 2'd2, 2'd1, 3'd3, 3'd0},
    {1'b1, 1'b0, 1'b1, 2'd0, 2'd3, 3'd1, 3'd0},
    {1'b1, 1'b0, 1'b0, 2'd1, 2'd0, 3'd2, 3'd0}
  };

  logic       clk, rst_n, ctl_we, scan_mode, ext_trig_n, tmr_trig;
  logic [7:2] ctl_wdata;
  logic [7:0] ctl_rdata;
  logic [0:0] grp_sel;
  logic [1:0] ch_sel;
  logic       conv_clk_en, conv_start, conv_done;
  logic [2:0] conv_ch, rd_ch;
  logic [9:0] conv_result, rd_data;

  int n_cmp = 0, n_bad = 0;
  int m_busy, m_cnt, m_seq, n_starts;
  logic [2:0] m_ch;
  int chlog [256];

  adc_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .scan_mode(scan_mode), .grp_sel(grp_sel),
    .ch_sel(ch_sel), .ext_trig_n(ext_trig_n), .tmr_trig(tmr_trig),
    .conv_clk_en(conv_clk_en), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_result(conv_result), .rd_ch(rd_ch),
    .rd_data(rd_data)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  // converter model: counts conversion clock enables after a start
  initial begin
    conv_done = 1'b0; conv_result = '0;
    m_busy = 0; m_cnt = 0; m_seq = 0; n_starts = 0; m_ch = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_start) begin
        m_busy = 1; m_cnt = 0; m_ch = conv_ch;
        chlog[n_starts % 256] = int'(conv_ch);
        n_starts++;
      end else if (m_busy != 0 && conv_clk_en) begin
        m_cnt++;
        if (m_cnt == CONV_TICKS) begin
          conv_done = 1'b1;
          conv_result = {m_ch, 7'(m_seq)};
          m_seq++;
          m_busy = 0;
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d[7:2];
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int k = 0; k < limit && !ctl_rdata[2]; k++) @(negedge clk);
  endtask

  initial begin
    int s0, sq, per, old, n;
    logic [12:0] e;
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; scan_mode = 1'b0;
    grp_sel = '0; ch_sel = '0; ext_trig_n = 1'b1; tmr_trig = 1'b0; rd_ch = '0;
    repeat (5) @(negedge clk);
    chk("R1 rdata", int'(ctl_rdata), 0);
    chk("R1 conv_start", int'(conv_start), 0);
    chk("R1 conv_clk_en", int'(conv_clk_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 readback and R4 launch latency
    wr(8'hFC);
    chk("R2 readback", int'(ctl_rdata), 8'hF8);
    chk("R4 no early start", int'(conv_start), 0);
    @(negedge clk);
    chk("R4 start pulse", int'(conv_start), 1);
    chk("R4 channel", int'(conv_ch), 0);
    wr(8'h00);
    chk("R2 cleared", int'(ctl_rdata), 0);

    // vector table: single and single-cycle scan runs
    for (int v = 0; v < NVEC; v++) begin
      e = VEC[v];
      scan_mode = e[12]; grp_sel = e[10]; ch_sel = e[9:8];
      n = int'(e[5:3]);
      s0 = n_starts; sq = m_seq;
      wr({1'b0, e[7:6], 1'b1, e[11], 3'b000});
      wait_done(n * CONV_TICKS * 32 + 64);
      chk("R12 done set", int'(ctl_rdata[2]), 1);
      if (e[12]) chk("R6 start cleared", int'(ctl_rdata[4]), 0);
      else       chk("R5 start cleared", int'(ctl_rdata[4]), 0);
      chk(e[12] ? "R6 count" : "R5 count", n_starts - s0, n);
      for (int i = 0; i < n; i++) begin
        int ch;
        ch = int'(e[10]) * 4 + int'(e[2:0]) + i;
        chk(e[12] ? "R6 order" : "R5 channel", chlog[(s0 + i) % 256], ch);
        rd_ch = 3'(ch);
        #1;
        chk("R11 result", int'(rd_data), (ch << 7) | ((sq + i) & 127));
      end
      wr(8'h00);
      chk("R12 cleared", int'(ctl_rdata), 0);
    end

    // R3 divider periods under a continuous scan
    scan_mode = 1'b1; grp_sel = '0; ch_sel = 2'd3;
    for (int s = 0; s < 4; s++) begin
      wr({1'b0, 2'(s), 1'b1, 1'b1, 3'b000});
      for (int k = 0; k < 80 && !conv_clk_en; k++) @(negedge clk);
      @(negedge clk);
      per = 1;
      while (!conv_clk_en && per < 80) begin
        @(negedge clk);
        per++;
      end
      chk("R3 period", per, 32 >> s);
      wr(8'h00);
      chk("R8 clk_en off", int'(conv_clk_en), 0);
    end
    per = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (conv_clk_en) per++;
    end
    chk("R3 idle no ticks", per, 0);

    // R7 continuous scan over two passes, then R8 stop
    scan_mode = 1'b1; grp_sel = '0; ch_sel = 2'd1;
    s0 = n_starts;
    wr(8'h78);
    wait_done(400);
    chk("R7 start kept pass1", int'(ctl_rdata[4]), 1);
    wr(8'h78);
    wait_done(400);
    chk("R7 start kept pass2", int'(ctl_rdata[4]), 1);
    chk("R7 order0", chlog[s0 % 256], 0);
    chk("R7 order1", chlog[(s0 + 1) % 256], 1);
    chk("R7 order2", chlog[(s0 + 2) % 256], 0);
    chk("R7 order3", chlog[(s0 + 3) % 256], 1);
    wr(8'h60);
    chk("R8 clk_en low", int'(conv_clk_en), 0);
    s0 = n_starts;
    repeat (300) @(negedge clk);
    chk("R8 no restart", n_starts - s0, 0);
    chk("R8 start low", int'(ctl_rdata[4]), 0);

    // R8 stop mid-conversion
    scan_mode = 1'b0; ch_sel = 2'd3; rd_ch = 3'd3;
    #1 old = int'(rd_data);
    wr(8'h70);
    repeat (30) @(negedge clk);
    wr(8'h60);
    repeat (200) @(negedge clk);
    chk("R8 no done flag", int'(ctl_rdata[2]), 0);
    chk("R8 result kept", int'(rd_data), old);

    // R9 triggers ignored while disabled
    s0 = n_starts;
    ext_trig_n = 1'b0;
    repeat (4) @(negedge clk);
    ext_trig_n = 1'b1; tmr_trig = 1'b1;
    @(negedge clk);
    tmr_trig = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 disabled start", int'(ctl_rdata[4]), 0);
    chk("R9 disabled conv", n_starts - s0, 0);

    // R9 external edge when enabled, R10 triggers during a run
    scan_mode = 1'b0; grp_sel = '0; ch_sel = 2'd1;
    wr(8'hE0);
    s0 = n_starts; sq = m_seq;
    ext_trig_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 ext edge start", int'(ctl_rdata[4]), 1);
    ext_trig_n = 1'b1;
    repeat (10) @(negedge clk);
    ext_trig_n = 1'b0; tmr_trig = 1'b1;
    @(negedge clk);
    tmr_trig = 1'b0;
    repeat (3) @(negedge clk);
    ext_trig_n = 1'b1;
    wait_done(200);
    repeat (20) @(negedge clk);
    chk("R10 one conversion", n_starts - s0, 1);
    chk("R10 start low", int'(ctl_rdata[4]), 0);
    rd_ch = 3'd1;
    #1 chk("R11 trig result", int'(rd_data), (1 << 7) | (sq & 127));

    // R9 timer trigger
    wr(8'hE0);
    tmr_trig = 1'b1;
    @(negedge clk);
    tmr_trig = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 timer start", int'(ctl_rdata[4]), 1);
    wait_done(200);
    chk("R12 done after trig", int'(ctl_rdata[2]), 1);

    // R12 write semantics of the done flag
    wr(8'hE4);
    chk("R12 write1 keeps", int'(ctl_rdata[2]), 1);
    wr(8'hE0);
    chk("R12 write0 clears", int'(ctl_rdata[2]), 0);

    summary();
    $finish;
  end

endmodule